// File: doc/BRIEF.md
# Cascadable Four-Bit Serializer with Clock Dividers

This block turns a four-bit parallel word into a serial NRZ stream, one bit for each falling edge of the bit clock. An internal phase counter sets when the four-stage shift chain captures a new word. The same counter drives a divide-by-4 and a divide-by-8 clock output, which upstream logic can use to pace its parallel words. Lane 0 of each word leaves first and lane 3 leaves last.

A mode input selects the capture interval. When it is low, a word is captured every four edges. When it is high, a word is captured every eight edges. In that mode the four edges after the last lane of a word shift out whatever arrived on the serial cascade input. Two units therefore combine into one eight-bit serializer: the upper unit's serial output drives the lower unit's cascade input, both units run in eight-bit mode, and they share a restart input. An active-high asynchronous restart clears the phase counter, which lets the system choose the edge on which conversion begins.

Top module: `ser4_cascade`

## Requirements
- R1: With `long_mode`=0, a word on `par_d` is captured on the first falling edge after restart and then on every fourth falling edge. After the capture edge and the three edges that follow, `ser_o` carries `par_d[0]`, `par_d[1]`, `par_d[2]` and `par_d[3]` of that word, in that order.
- R2: With `long_mode`=1, captures happen on every eighth falling edge. At offsets 0 to 3 from a capture edge, `ser_o` carries lanes 0 to 3. At offset p in 4 to 7, `ser_o` carries the value `casc_i` had just before edge p-3.
- R3: Two units in eight-bit mode, with the upper unit's `ser_o` wired to the lower unit's `casc_i` and a shared restart, emit on the lower `ser_o` lanes 0 to 3 of the lower word and then lanes 0 to 3 of the upper word. Both words are the ones present at the same capture edge.
- R4: With `long_mode`=0, `casc_i` has no effect on `ser_o`.
- R5: While `restart` is high, `div4_o` and `div8_o` are low. They go low as soon as `restart` rises, without waiting for a clock edge.
- R6: On the first falling edge after `restart` falls, the word on `par_d` is captured and its lane 0 appears on `ser_o`.
- R7: After the k-th falling edge since restart (k counted from 0), `div4_o` equals bit 1 of (k+1) mod 8 and `div8_o` equals bit 2 of it. This gives each divided clock a 50% duty cycle.
- R8: A restart in the middle of a word drops the rest of that word. Output realigns so that the next edge after release starts a fresh word, as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its falling edge |
| restart | input | 1 | Active-high asynchronous clear of the phase counter |
| long_mode | input | 1 | 0: capture every 4 edges; 1: capture every 8 edges |
| par_d | input | 4 | Parallel word, lane 0 sent first |
| casc_i | input | 1 | Serial cascade input fed into the top stage |
| ser_o | output | 1 | Serial data output |
| div4_o | output | 1 | Bit clock divided by four |
| div8_o | output | 1 | Bit clock divided by eight |

## Verification
A capture and a shift of cascade data into the top stage compete for the same flop on every capture edge. The capture must win, or a cascade bit would corrupt lane 3. Random cascade and parallel data change on every cycle, so each capture edge sees both sources active, and lane 3 is compared against the captured word. A restart can also land in the middle of a word while the chain still holds stale bits. The bench asserts restart at word offset 5 and checks that the first edge after release gives lane 0 of the new word, with the dividers back at phase zero.

// File: rtl/ser4_pkg.sv
package ser4_pkg;

  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_LONG  = 1'b1
  } ser_mode_e;

endpackage

// File: rtl/ser4_phase_counter.sv
module ser4_phase_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             restart,
  output logic [CNT_W-1:0] phase_q
);

  logic [CNT_W-1:0] phase_d;

  always_comb begin
    phase_d = phase_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(negedge clk or posedge restart) begin
    if (restart) phase_q <= '0;
    else         phase_q <= phase_d;
  end

endmodule

// File: rtl/ser4_load_gen.sv
module ser4_load_gen
  import ser4_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int LANE_W = 2
) (
  input  logic [CNT_W-1:0] phase_q,
  input  ser_mode_e        mode,
  output logic             load
);

  logic short_wrap;
  logic long_wrap;

  always_comb begin
    short_wrap = (phase_q[LANE_W-1:0] == '0);
    long_wrap  = (phase_q == '0);
    load       = (mode == MODE_LONG) ? long_wrap : short_wrap;
  end

endmodule

// File: rtl/ser4_shift_chain.sv
module ser4_shift_chain #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             load,
  input  logic [LANES-1:0] par_d,
  input  logic             casc_i,
  output logic             ser_o
);

  logic [LANES-1:0] stage_q;
  logic [LANES-1:0] stage_d;

  for (genvar i = 0; i < LANES; i++) begin : g_stage
    logic from_above;
    if (i == LANES - 1) begin : g_top
      assign from_above = casc_i;
    end else begin : g_mid
      assign from_above = stage_q[i+1];
    end
    always_comb begin
      stage_d[i] = load ? par_d[i] : from_above;
    end
  end

  always_ff @(negedge clk) begin
    stage_q <= stage_d;
  end

  assign ser_o = stage_q[0];

endmodule

// File: rtl/ser4_cascade.sv
module ser4_cascade
  import ser4_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             restart,
  input  logic             long_mode,
  input  logic [LANES-1:0] par_d,
  input  logic             casc_i,
  output logic             ser_o,
  output logic             div4_o,
  output logic             div8_o
);

  localparam int LANE_W = $clog2(LANES);
  localparam int CNT_W  = LANE_W + 1;

  logic [CNT_W-1:0] phase_q;
  logic             load;
  ser_mode_e        mode;

  assign mode = ser_mode_e'(long_mode);

  ser4_phase_counter #(.CNT_W(CNT_W)) u_phase (
    .clk     (clk),
    .restart (restart),
    .phase_q (phase_q)
  );

  ser4_load_gen #(.CNT_W(CNT_W), .LANE_W(LANE_W)) u_load (
    .phase_q (phase_q),
    .mode    (mode),
    .load    (load)
  );

  ser4_shift_chain #(.LANES(LANES)) u_chain (
    .clk    (clk),
    .load   (load),
    .par_d  (par_d),
    .casc_i (casc_i),
    .ser_o  (ser_o)
  );

  assign div4_o = phase_q[LANE_W-1];
  assign div8_o = phase_q[LANE_W];

  // R1
  load_div4_low_chk: assert property (@(negedge clk) disable iff (restart)
    load |-> !div4_o);

  // R2
  load_div8_low_chk: assert property (@(negedge clk) disable iff (restart)
    (load && long_mode) |-> !div8_o);

  // R6
  lane0_first_chk: assert property (@(negedge clk) disable iff (restart)
    load |=> (ser_o == $past(par_d[0])));

  // R7
  div4_high_hold_chk: assert property (@(negedge clk) disable iff (restart)
    $rose(div4_o) |=> div4_o);

  // R7
  div4_low_hold_chk: assert property (@(negedge clk) disable iff (restart)
    $fell(div4_o) |=> !div4_o);

  // R7
  div8_step_chk: assert property (@(negedge clk) disable iff (restart)
    $rose(div8_o) |-> $fell(div4_o));

endmodule

// File: tb/test_ser4_cascade.sv
module test_ser4_cascade;

  localparam int CLK_PERIOD = 10;
  localparam int HIST = 256;

  logic       clk;
  logic       restart;
  logic       long_mode;
  logic [3:0] d_lo;
  logic [3:0] d_hi;
  logic       sin_hi;
  logic       ser_lo, ser_hi;
  logic       div4_lo, div8_lo, div4_hi, div8_hi;

  logic [3:0] lo_hist [HIST];
  logic [3:0] hi_hist [HIST];
  logic       sin_hist[HIST];

  int k;
  int checks;
  int errors;

  ser4_cascade i_ser4_cascade (
    .clk (clk), .restart (restart), .long_mode (long_mode),
    .par_d (d_lo), .casc_i (ser_hi),
    .ser_o (ser_lo), .div4_o (div4_lo), .div8_o (div8_lo)
  );

  ser4_cascade i_ser4_cascade_hi (
    .clk (clk), .restart (restart), .long_mode (long_mode),
    .par_d (d_hi), .casc_i (sin_hi),
    .ser_o (ser_hi), .div4_o (div4_hi), .div8_o (div8_hi)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual %b expected %b", req, what, k, act, exp);
    end
  endtask

  task automatic do_restart(input logic m);
    @(posedge clk);
    restart   = 1'b1;
    long_mode = m;
    #1;
    chk("R5", "div4 during restart", div4_lo, 1'b0);
    chk("R5", "div8 during restart", div8_lo, 1'b0);
    chk("R5", "upper div4 during restart", div4_hi, 1'b0);
    @(posedge clk);
    restart = 1'b0;
    k = 0;
  endtask

  task automatic run_phase(input int n, input bit after_mid);
    for (int i = 0; i < n; i++) begin
      logic [3:0] rv;
      logic       exp_lo, exp_hi;
      logic [2:0] ph;
      int         p, b;
      string      tag_lo, tag_hi;
      rv = 4'($urandom); d_lo = rv; lo_hist[k] = rv;
      rv = 4'($urandom); d_hi = rv; hi_hist[k] = rv;
      sin_hi = 1'($urandom); sin_hist[k] = sin_hi;
      @(posedge clk);
      if (long_mode == 1'b0) begin
        p = k % 4; b = k - p;
        exp_lo = lo_hist[b][p];
        exp_hi = hi_hist[b][p];
        tag_lo = "R1";
        tag_hi = (p == 0) ? "R1" : "R4";
      end else begin
        p = k % 8; b = k - p;
        exp_lo = (p < 4) ? lo_hist[b][p] : hi_hist[b][p-4];
        exp_hi = (p < 4) ? hi_hist[b][p] : sin_hist[k-3];
        tag_lo = "R3";
        tag_hi = "R2";
      end
      if (k == 0) tag_lo = after_mid ? "R8" : "R6";
      chk(tag_lo, "lower ser_o", ser_lo, exp_lo);
      chk(tag_hi, "upper ser_o", ser_hi, exp_hi);
      ph = 3'((k + 1) % 8);
      chk("R7", "div4", div4_lo, ph[1]);
      chk("R7", "div8", div8_lo, ph[2]);
      k++;
    end
  endtask

  initial begin
    checks    = 0;
    errors    = 0;
    k         = 0;
    restart   = 1'b1;
    long_mode = 1'b0;
    d_lo      = '0;
    d_hi      = '0;
    sin_hi    = 1'b0;
    #2;
    chk("R5", "div4 at reset", div4_lo, 1'b0);
    chk("R5", "div8 at reset", div8_lo, 1'b0);
    // R1, R4: four-lane mode with busy cascade input
    do_restart(1'b0);
    run_phase(48, 1'b0);
    // R2, R3: eight-bit cascade
    do_restart(1'b1);
    run_phase(64, 1'b0);
    // R8: restart at word offset 5, then realign
    do_restart(1'b1);
    run_phase(6, 1'b0);
    do_restart(1'b1);
    run_phase(40, 1'b1);
    // R8 in four-lane mode, restart mid-word
    do_restart(1'b0);
    run_phase(2, 1'b0);
    do_restart(1'b0);
    run_phase(24, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule